// File: doc/BRIEF.md
# Serial Core-Voltage Command Receiver

This block is a write-only slave on a three-wire serial link (active-low select, serial clock, serial data). While select is held low it takes one data bit on each rising edge of the serial clock, most significant bit first, and builds 16-bit command words. Once a word is complete it takes the 5-bit core-voltage code from the top of the word and holds it as the new setting. A partial word is never committed.

All three serial lines are asynchronous to the system clock. Each line goes through a two-flop synchronizer, and serial clock edges are detected in the system clock domain. Next to the committed code, the block outputs the matching regulator target in millivolts: a fixed 600 mV base plus 25 mV for each code step. It also gives a single-cycle pulse whenever a new code is committed.

Top module: `vcore_serial_rx`

## Requirements
- R1: While `rst` is high, and after it is released, `code_o` equals the parameter `RESET_CODE` (default 8), `mv_o` is 800 and `upd_o` is 0, until a full word is received.
- R2: Data is sampled on rising edges of `ser_clk` while `ser_cs_n` is 0, most significant bit first. The committed code is word bits 15..11, with bit 15 as the code MSB.
- R3: Word bits 10..6 are reserved and have no effect on `code_o` or `mv_o`.
- R4: Word bits 5..0 are unused and have no effect on `code_o` or `mv_o`.
- R5: The code commits as soon as the sixteenth bit is taken, even if `ser_cs_n` stays low. After fifteen bits, `code_o` has not changed.
- R6: If `ser_cs_n` returns to 1 before sixteen bits arrive, the partial word is dropped. `code_o` keeps its value and no `upd_o` pulse occurs.
- R7: `mv_o` equals 600 + 25 × `code_o`, so it ranges from 600 to 1375.
- R8: Each committed word produces exactly one `upd_o` pulse, one system clock long, in the same cycle that `code_o` takes its new value.
- R9: Within one select frame, bits after the sixteenth are ignored until `ser_cs_n` goes high again.
- R10: A new frame that starts after `ser_cs_n` is released is received from bit 15 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_cs_n | input | 1 | Serial select, active low, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| code_o | output | 5 | Committed core-voltage code |
| mv_o | output | 11 | Target voltage in millivolts |
| upd_o | output | 1 | One-cycle pulse on each commit |

## Verification
The hardest situation to reach is a select frame that does not hold exactly sixteen bits. That means a frame cut short at fifteen bits, or one that runs past sixteen. Only at those boundaries do framing faults show up at the outputs. The bench sends frames with an explicit bit count and an optional hold of the select line, so it can check the outputs between the fifteenth bit and the release and after each extra bit. It also keeps a running count of update pulses, which shows when a dropped frame has committed by mistake.

// File: rtl/svc_pkg.sv
package svc_pkg;
    localparam int WORD_BITS = 16;
    localparam int CODE_BITS = 5;
    localparam int CODE_TOP  = 15;
    localparam int BASE_MV   = 600;
    localparam int STEP_MV   = 25;
    localparam int MAX_MV    = BASE_MV + STEP_MV * ((1 << CODE_BITS) - 1);
    localparam int MV_BITS   = $clog2(MAX_MV + 1);
    localparam int CNT_BITS  = $clog2(WORD_BITS + 1);

    typedef logic [CODE_BITS-1:0] code_t;
    typedef logic [MV_BITS-1:0]   mv_t;

    typedef struct packed {
        logic  valid;
        code_t code;
    } cmd_t;

    function automatic mv_t code_to_mv(input code_t c);
        return mv_t'(BASE_MV + STEP_MV * int'(c));
    endfunction
endpackage

// File: rtl/svc_sync.sv
module svc_sync #(
    parameter int LINES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end
endmodule

// File: rtl/svc_framer.sv
module svc_framer
    import svc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdat_i,
    output cmd_t cmd_o
);
    logic                 sclk_prev_q;
    logic [WORD_BITS-2:0] shift_q;
    logic [CNT_BITS-1:0]  count_q;
    logic                 rise;

    always_comb rise = sclk_i && !sclk_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b0;
            shift_q     <= '0;
            count_q     <= '0;
            cmd_o       <= '0;
        end else begin
            sclk_prev_q <= sclk_i;
            cmd_o.valid <= 1'b0;
            if (!sel_i) begin
                count_q <= '0;
            end else if (rise && count_q < CNT_BITS'(WORD_BITS)) begin
                shift_q <= {shift_q[WORD_BITS-3:0], sdat_i};
                count_q <= count_q + 1'b1;
                if (count_q == CNT_BITS'(WORD_BITS - 1)) begin
                    cmd_o.valid <= 1'b1;
                    cmd_o.code  <= shift_q[CODE_TOP-1 -: CODE_BITS];
                end
            end
        end
    end
endmodule

// File: rtl/svc_commit.sv
module svc_commit
    import svc_pkg::*;
#(
    parameter code_t RESET_CODE = code_t'(8)
) (
    input  logic  clk,
    input  logic  rst,
    input  cmd_t  cmd_i,
    output code_t code_o,
    output mv_t   mv_o,
    output logic  upd_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= RESET_CODE;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= cmd_i.valid;
            if (cmd_i.valid) code_o <= cmd_i.code;
        end
    end

    always_comb mv_o = code_to_mv(code_o);
endmodule

// File: rtl/vcore_serial_rx.sv
module vcore_serial_rx
    import svc_pkg::*;
#(
    parameter code_t RESET_CODE = code_t'(8)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_cs_n,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    output logic [CODE_BITS-1:0] code_o,
    output logic [MV_BITS-1:0]   mv_o,
    output logic                 upd_o
);
    logic [2:0] sync_lines;
    cmd_t       cmd;

    svc_sync #(.LINES(3)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({~ser_cs_n, ser_clk, ser_data}),
        .sync_o  (sync_lines)
    );

    svc_framer u_framer (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (sync_lines[2]),
        .sclk_i (sync_lines[1]),
        .sdat_i (sync_lines[0]),
        .cmd_o  (cmd)
    );

    svc_commit #(.RESET_CODE(RESET_CODE)) u_commit (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd),
        .code_o (code_o),
        .mv_o   (mv_o),
        .upd_o  (upd_o)
    );
endmodule

// File: rtl/svc_checker.sv
module svc_checker
    import svc_pkg::*;
#(
    parameter code_t RESET_CODE = code_t'(8)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CODE_BITS-1:0] code_o,
    input logic [MV_BITS-1:0]   mv_o,
    input logic                 upd_o
);
    // R1
    reset_code_chk: assert property (@(posedge clk)
        rst |=> (code_o == RESET_CODE && !upd_o));

    // R8
    upd_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd_o |=> !upd_o);

    // R6
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_o |-> $stable(code_o));

    // R7
    mv_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(mv_o) >= BASE_MV) && (int'(mv_o) <= MAX_MV)
        && ((int'(mv_o) - BASE_MV) % STEP_MV == 0));
endmodule

bind vcore_serial_rx svc_checker #(.RESET_CODE(RESET_CODE)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .code_o (code_o),
    .mv_o   (mv_o),
    .upd_o  (upd_o)
);

// File: tb/vcore_serial_rx_test.sv
module vcore_serial_rx_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_cs_n = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [4:0]  code_o;
    logic [10:0] mv_o;
    logic        upd_o;

    int n_checks = 0;
    int n_fail   = 0;
    int upd_cnt  = 0;
    int upd_mark = 0;

    vcore_serial_rx uut (
        .clk(clk), .rst(rst), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
        .ser_data(ser_data), .code_o(code_o), .mv_o(mv_o), .upd_o(upd_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (!rst && upd_o) upd_cnt <= upd_cnt + 1;

    localparam int NV = 8;
    localparam logic [15:0] VEC_WORD [NV] = '{
        16'h0000, 16'hF800, 16'h07FF, 16'hA83F,
        16'h5000, 16'h8000, 16'h0800, 16'hFFFF};
    localparam logic [4:0] VEC_CODE [NV] = '{
        5'd0, 5'd31, 5'd0, 5'd21, 5'd10, 5'd16, 5'd1, 5'd31};

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] bits, input int n, input bit rel);
        ser_clk  = 1'b0;
        ser_cs_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            ser_clk  = 1'b0;
            wait_clk(4);
            ser_clk  = 1'b1;
            wait_clk(4);
        end
        wait_clk(4);
        if (rel) begin
            ser_cs_n = 1'b1;
            wait_clk(8);
        end
    endtask

    task automatic check_code(input string req, input int exp_code, input int exp_upd);
        check(req, int'(code_o), exp_code);
        check({req, " mv"}, int'(mv_o), 600 + 25 * exp_code);
        check({req, " upd"}, upd_cnt - upd_mark, exp_upd);
        upd_mark = upd_cnt;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_clk(5);
        // R1: values during reset
        check("R1 code in reset", int'(code_o), 8);
        check("R1 upd in reset", int'(upd_o), 0);
        rst = 1'b0;
        wait_clk(5);
        // R1, R7: after release
        check_code("R1 after reset", 8, 0);

        // R2, R3, R4, R7, R8, R10: table walk
        for (int v = 0; v < NV; v++) begin
            send({16'h0, VEC_WORD[v]}, 16, 1'b1);
            check_code($sformatf("R2/R3/R4/R8 vec%0d", v), int'(VEC_CODE[v]), 1);
        end

        // R5: commit at the sixteenth bit with select still low
        send({16'h0, 16'h3000}, 15, 1'b0);
        check_code("R5 fifteen bits", 31, 0);
        ser_cs_n = 1'b1;
        wait_clk(8);
        // R6: dropped partial frame
        check_code("R6 partial dropped", 31, 0);

        send({16'h0, 16'h3000}, 16, 1'b0);
        check_code("R5 commit before release", 6, 1);
        ser_cs_n = 1'b1;
        wait_clk(8);

        // R9: extra bits ignored
        send({12'h0, 16'h5800, 4'hF}, 20, 1'b0);
        check_code("R9 extra bits held", 11, 1);
        ser_cs_n = 1'b1;
        wait_clk(8);
        check_code("R9 extra bits after release", 11, 0);

        // R10: next frame realigns at bit 15
        send({16'h0, 16'h9000}, 16, 1'b1);
        check_code("R10 new frame", 18, 1);

        // R6: cut short after one bit
        send({31'h0, 1'b1}, 1, 1'b1);
        check_code("R6 one bit", 18, 0);

        // R1: reset mid-run
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(3);
        upd_mark = upd_cnt;
        check_code("R1 reapplied", 8, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule